// File: doc/BRIEF.md
# Systolic Horner Polynomial Evaluator

This block evaluates a polynomial of fixed degree n at a stream of input points with Horner's rule. It is a linear chain of 2n registered stages that all step on the same clock edge, and each result moves one stage to the right per cycle. The stages alternate. A multiply stage scales the partial result arriving from its left by x. The add stage after it adds one coefficient. The leftmost stage starts from the top coefficient a_n, so the chain computes y = (…((a_n·x + a_{n-1})·x + a_{n-2})…)·x + a_0, and a_0 is added in the last stage.

Each partial result carries its own copy of x and a valid flag as it moves down the chain. A new point can therefore enter on every cycle, and cycles with no input leave gaps that flow through harmlessly. The n+1 coefficients are held inside the stages that use them and are loaded through a simple address/data/write-enable port. A write reaches each stage on a delay that matches that stage's depth. As a result, an evaluation always sees one consistent coefficient set: the one in force when the evaluation entered the chain.

Top module: `horner_eval`

## Requirements
- R1: While reset is active and on the first cycle after it is released, yValid is 0 and yOut is 0. Every coefficient resets to 0, so any x evaluated before a write gives y = 0.
- R2: If xValid is high in cycle c, then yValid is high in cycle c+2n, where n is DEGREE (8 cycles by default). Each accepted x produces exactly one result, and results leave in the order their inputs entered. yValid is low in every other cycle.
- R3: yOut equals a_n·x^n + … + a_1·x + a_0, computed as Horner steps, where a_k is the value last written to coefficient address k (k = 0…n). Address n holds the top coefficient, which seeds the first stage. Address 0 holds the constant term, which is added last. With x = 0, the result is a_0.
- R4: A new x may be presented on every cycle. Back-to-back inputs each produce a correct result on consecutive cycles.
- R5: A cycle with xValid low is a bubble. It produces no result, and it does not change the results of the evaluations before or after it, whatever value xIn holds during the bubble.
- R6: All arithmetic is 16-bit two's complement. Every multiply and every add keeps only the low 16 bits of its result, so y equals the exact polynomial value modulo 2^16.
- R7: A coefficient write (coefWe high in cycle w) applies to every evaluation whose xValid is high in a cycle after w. Evaluations entering in cycle w or earlier use the previous value, even while they are still inside the chain.
- R8: A write to an address greater than n changes no coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| xValid | input | 1 | xIn holds a point to evaluate this cycle |
| xIn | input | 16 | Evaluation point x, two's complement |
| coefWe | input | 1 | Write coefAddr with coefData this cycle |
| coefAddr | input | 3 | Coefficient index k (0 = constant term, n = top term) |
| coefData | input | 16 | New coefficient value, two's complement |
| yValid | output | 1 | yOut holds a finished result |
| yOut | output | 16 | Polynomial value, low 16 bits |

## Verification
The main function is exercised with one coefficient set. Points are streamed back to back with no gaps, which separates per-stage x tracking from any shared x. The same points are then sent with bubbles interleaved, carrying junk x values, which shows whether gaps leak into neighbouring results. Points of zero, one and both signs distinguish a misplaced constant, a swapped coefficient order and sign handling. A point whose exact value exceeds 16 bits checks the wraparound. Coefficient writes are issued in the same cycle as an input and just before the next one, at the seed end and at the constant end, to pin down which evaluation first sees the new value. A write to an address above n then confirms that no coefficient changes.

// File: rtl/horner_pkg.sv
package horner_pkg;

  // Per-stage strobe: the data entering this stage is a real evaluation.
  typedef struct packed {
    logic advance;
  } stageStb_t;

  // Per-coefficient strobe: this stage's local coefficient copy loads now.
  typedef struct packed {
    logic load;
  } coefStb_t;

endpackage

// File: rtl/horner_ctrl.sv
// Control half: valid flags travel with the data, and coefficient writes
// travel along a token line so each stage sees them with its own delay.
module horner_ctrl
  import horner_pkg::*;
#(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xValid,
  input  logic              coefWe,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output stageStb_t         stb     [2*DEGREE],
  output coefStb_t          cstb    [DEGREE+1],
  output logic [DATA_W-1:0] coefNew [DEGREE+1],
  output logic              outValid
);

  localparam int STAGES = 2 * DEGREE;
  localparam int TOKENS = STAGES - 1;

  logic [STAGES-1:0]             vld;
  logic [TOKENS-1:0]             tokWe;
  logic [TOKENS-1:0][ADDR_W-1:0] tokAddr;
  logic [TOKENS-1:0][DATA_W-1:0] tokData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld     <= '0;
      tokWe   <= '0;
      tokAddr <= '0;
      tokData <= '0;
    end else begin
      vld[0]     <= xValid;
      tokWe[0]   <= coefWe;
      tokAddr[0] <= coefAddr;
      tokData[0] <= coefData;
      for (int s = 1; s < STAGES; s++) begin
        vld[s] <= vld[s-1];
      end
      for (int m = 1; m < TOKENS; m++) begin
        tokWe[m]   <= tokWe[m-1];
        tokAddr[m] <= tokAddr[m-1];
        tokData[m] <= tokData[m-1];
      end
    end
  end

  // Stage 0 takes new data straight from the input; later stages take the
  // valid flag of the stage before them.
  assign stb[0].advance = xValid;
  for (genvar s = 1; s < STAGES; s++) begin : g_adv
    assign stb[s].advance = vld[s-1];
  end

  // The top coefficient copy lives in stage 0 and loads directly from the
  // port. Copy k (k < n) lives in stage 2(n-k)-1 and loads from the token
  // that has travelled that many cycles behind the write.
  for (genvar k = 0; k <= DEGREE; k++) begin : g_coef
    if (k == DEGREE) begin : g_seed
      assign cstb[k].load = coefWe && (coefAddr == ADDR_W'(k));
      assign coefNew[k]   = coefData;
    end else begin : g_tap
      localparam int TAP = 2 * (DEGREE - k) - 2;
      assign cstb[k].load = tokWe[TAP] && (tokAddr[TAP] == ADDR_W'(k));
      assign coefNew[k]   = tokData[TAP];
    end
  end

  assign outValid = vld[STAGES-1];

endmodule

// File: rtl/horner_datapath.sv
// Datapath half: alternating multiply-by-x and add-coefficient stages,
// each stage holding its own result, its copy of x and its coefficient.
module horner_datapath
  import horner_pkg::*;
#(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] xIn,
  input  stageStb_t         stb     [2*DEGREE],
  input  coefStb_t          cstb    [DEGREE+1],
  input  logic [DATA_W-1:0] coefNew [DEGREE+1],
  output logic [DATA_W-1:0] yOut
);

  localparam int STAGES = 2 * DEGREE;

  logic [DATA_W-1:0] stageVal [STAGES];
  logic [DATA_W-1:0] stageX   [STAGES-1];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [DATA_W-1:0] valQ;
    assign stageVal[s] = valQ;

    if (s == 0) begin : g_seed
      // Seed with the top coefficient and apply the first multiply.
      logic [DATA_W-1:0] coefQ;
      logic [DATA_W-1:0] xQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          coefQ <= '0;
          valQ  <= '0;
          xQ    <= '0;
        end else begin
          if (cstb[DEGREE].load) coefQ <= coefNew[DEGREE];
          if (stb[s].advance) begin
            valQ <= coefQ * xIn;
            xQ   <= xIn;
          end
        end
      end
      assign stageX[s] = xQ;
    end else if (s % 2 == 1) begin : g_add
      localparam int K = DEGREE - (s + 1) / 2;
      logic [DATA_W-1:0] coefQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          coefQ <= '0;
          valQ  <= '0;
        end else begin
          if (cstb[K].load) coefQ <= coefNew[K];
          if (stb[s].advance) valQ <= stageVal[s-1] + coefQ;
        end
      end
      if (s < STAGES - 1) begin : g_xfwd
        logic [DATA_W-1:0] xQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)               xQ <= '0;
          else if (stb[s].advance) xQ <= stageX[s-1];
        end
        assign stageX[s] = xQ;
      end
    end else begin : g_mul
      logic [DATA_W-1:0] xQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          valQ <= '0;
          xQ   <= '0;
        end else if (stb[s].advance) begin
          valQ <= stageVal[s-1] * stageX[s-1];
          xQ   <= stageX[s-1];
        end
      end
      assign stageX[s] = xQ;
    end
  end

  assign yOut = stageVal[STAGES-1];

endmodule

// File: rtl/horner_eval.sv
// Thin top: control and datapath joined by strobe structs.
module horner_eval
  import horner_pkg::*;
#(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xValid,
  input  logic [DATA_W-1:0] xIn,
  input  logic              coefWe,
  input  logic [ADDR_W-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData,
  output logic              yValid,
  output logic [DATA_W-1:0] yOut
);

  stageStb_t         stb     [2*DEGREE];
  coefStb_t          cstb    [DEGREE+1];
  logic [DATA_W-1:0] coefNew [DEGREE+1];

  horner_ctrl #(
    .DEGREE (DEGREE),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .xValid   (xValid),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .stb      (stb),
    .cstb     (cstb),
    .coefNew  (coefNew),
    .outValid (yValid)
  );

  horner_datapath #(
    .DEGREE (DEGREE),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .xIn     (xIn),
    .stb     (stb),
    .cstb    (cstb),
    .coefNew (coefNew),
    .yOut    (yOut)
  );

endmodule

// File: rtl/horner_chk.sv
// Checker: keeps its own shadow of accepted inputs and of the constant
// term, and compares the outputs against them.
module horner_chk #(
  parameter int DEGREE = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              xValid,
  input logic [DATA_W-1:0] xIn,
  input logic              coefWe,
  input logic [ADDR_W-1:0] coefAddr,
  input logic [DATA_W-1:0] coefData,
  input logic              yValid,
  input logic [DATA_W-1:0] yOut
);

  localparam int STAGES = 2 * DEGREE;

  logic [STAGES-1:0]             vShadow;
  logic [STAGES-1:0]             zShadow;
  logic [STAGES-1:0][DATA_W-1:0] a0Shadow;
  logic [DATA_W-1:0]             a0Model;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vShadow  <= '0;
      zShadow  <= '0;
      a0Shadow <= '0;
      a0Model  <= '0;
    end else begin
      vShadow[0]  <= xValid;
      zShadow[0]  <= xValid && (xIn == '0);
      a0Shadow[0] <= a0Model;
      for (int s = 1; s < STAGES; s++) begin
        vShadow[s]  <= vShadow[s-1];
        zShadow[s]  <= zShadow[s-1];
        a0Shadow[s] <= a0Shadow[s-1];
      end
      if (coefWe && coefAddr == '0) a0Model <= coefData;
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!yValid && yOut == '0)
        else $error("outputs active during reset"); // R1
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    yValid == vShadow[STAGES-1]); // R2

  AST_ZERO_X_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (yValid && zShadow[STAGES-1]) |-> yOut == a0Shadow[STAGES-1]); // R7

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    yValid |-> !$isunknown(yOut)); // R3

endmodule

bind horner_eval horner_chk #(
  .DEGREE (DEGREE),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .xValid   (xValid),
  .xIn      (xIn),
  .coefWe   (coefWe),
  .coefAddr (coefAddr),
  .coefData (coefData),
  .yValid   (yValid),
  .yOut     (yOut)
);

// File: tb/horner_eval_tb.sv
`timescale 1ns/1ps
module horner_eval_tb;

  localparam int DEGREE = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int LAT    = 2 * DEGREE;
  localparam int NVEC   = 9;

  // {x, expected y} with a_4..a_0 = 1,2,3,4,5
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0005, 32'h0001_000F, 32'h0002_0039, 32'hFFFF_0003,
    32'h0003_00B3, 32'hFFFE_0009, 32'h000A_3039, 32'h0014_B485,
    32'hFFFD_002F
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              xValid;
  logic [DATA_W-1:0] xIn;
  logic              coefWe;
  logic [ADDR_W-1:0] coefAddr;
  logic [DATA_W-1:0] coefData;
  logic              yValid;
  logic [DATA_W-1:0] yOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  logic [DATA_W-1:0] coefM [DEGREE+1];
  logic [DATA_W-1:0] expQ   [$];
  int                issueQ [$];
  string             tagQ   [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  horner_eval #(.DEGREE(DEGREE), .DATA_W(DATA_W)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .xValid   (xValid),
    .xIn      (xIn),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .yValid   (yValid),
    .yOut     (yOut)
  );

  function automatic logic [DATA_W-1:0] model(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] acc;
    acc = coefM[DEGREE];
    for (int k = DEGREE - 1; k >= 0; k--) begin
      acc = acc * x;
      acc = acc + coefM[k];
    end
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // One cycle of stimulus; pushes the expected result if x is valid and
  // applies any in-range write to the model after the push (R7, R8).
  task automatic drive(input bit v, input logic [DATA_W-1:0] x,
                       input logic [DATA_W-1:0] expY, input bit we,
                       input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    xValid   = v;
    xIn      = x;
    coefWe   = we;
    coefAddr = a;
    coefData = d;
    if (v) begin
      expQ.push_back(expY);
      issueQ.push_back(cyc);
      tagQ.push_back(tag);
    end
    if (we && int'(a) <= DEGREE) coefM[a] = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 16'h5A5A, '0, 1'b0, '0, '0, "");
  endtask

  // Output monitor: value per the tagged requirement, latency per R2.
  always @(negedge clk) begin
    if (rstN === 1'b1 && yValid === 1'b1) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected output", int'(yOut), 0);
      end else begin
        automatic logic [DATA_W-1:0] e = expQ.pop_front();
        automatic int                t = issueQ.pop_front();
        automatic string             g = tagQ.pop_front();
        check(yOut === e, g, "result value", int'(yOut), int'(e));
        check(cyc - t == LAT, "R2", "latency", cyc - t, LAT);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b1; xValid = 1'b0; xIn = '0;
    coefWe = 1'b0; coefAddr = '0; coefData = '0;
    for (int k = 0; k <= DEGREE; k++) coefM[k] = '0;
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(yValid === 1'b0, "R1", "yValid in reset", int'(yValid), 0);
    check(yOut === '0, "R1", "yOut in reset", int'(yOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(yValid === 1'b0, "R1", "yValid after release", int'(yValid), 0);

    // R1: coefficients start at zero
    drive(1'b1, 16'd7, 16'd0, 1'b0, '0, '0, "R1");
    idle(LAT + 2);

    // Load a_k = 5 - k
    for (int k = 0; k <= DEGREE; k++)
      drive(1'b0, '0, '0, 1'b1, ADDR_W'(k), DATA_W'(5 - k), "");

    // R3/R4/R6: table streamed back to back
    for (int i = 0; i < NVEC; i++)
      drive(1'b1, VEC[i][31:16], VEC[i][15:0], 1'b0, '0, '0,
            (VEC[i][31:16] == 16'd20) ? "R6" : ((i % 2 == 0) ? "R3" : "R4"));
    idle(LAT + 2);

    // R5: bubbles with junk x between valid points
    drive(1'b1, 16'd2,    model(16'd2),    1'b0, '0, '0, "R5");
    drive(1'b0, 16'h7FFF, '0,              1'b0, '0, '0, "");
    drive(1'b1, 16'hFFFF, model(16'hFFFF), 1'b0, '0, '0, "R5");
    drive(1'b1, 16'd3,    model(16'd3),    1'b0, '0, '0, "R5");
    drive(1'b0, 16'h1234, '0,              1'b0, '0, '0, "");
    drive(1'b0, 16'h8000, '0,              1'b0, '0, '0, "");
    drive(1'b1, 16'd10,   model(16'd10),   1'b0, '0, '0, "R5");
    idle(LAT + 2);

    // R6: extreme negative point wraps
    drive(1'b1, 16'h8000, model(16'h8000), 1'b0, '0, '0, "R6");
    idle(LAT + 2);

    // R7: writes at the constant end and the seed end with evaluations in flight
    drive(1'b1, 16'd1, 16'd15,  1'b1, 3'd0, 16'd100, "R7");
    drive(1'b1, 16'd1, 16'd110, 1'b1, 3'd4, 16'd7,   "R7");
    drive(1'b1, 16'd1, 16'd116, 1'b0, '0,   '0,      "R7");
    idle(LAT + 2);

    // R8: writes above the top address leave coefficients unchanged
    drive(1'b0, '0, '0, 1'b1, 3'd5, 16'd999, "");
    drive(1'b0, '0, '0, 1'b1, 3'd6, 16'd777, "");
    drive(1'b0, '0, '0, 1'b1, 3'd7, 16'd555, "");
    drive(1'b1, 16'd1, 16'd116,      1'b0, '0, '0, "R8");
    drive(1'b1, 16'd2, model(16'd2), 1'b0, '0, '0, "R8");
    drive(1'b1, 16'd0, 16'd100,      1'b0, '0, '0, "R8");
    idle(LAT + 2);

    check(expQ.size() == 0, "R2", "missing outputs", expQ.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule